// File: doc/BRIEF.md
# Immediate-Operand Integer Execute Stage

This block is the execute step for register-plus-immediate integer instructions in a 64-bit pipeline. Each cycle it may accept one decoded operation with the source register value, a 16-bit immediate, the destination register index and two mode flags. The flags are narrow mode and privileged mode. One clock edge later it presents the outcome as either a register write-back or an exception cause. It never presents both.

It covers six operations:
- a word add that traps on signed overflow, and a word add that never traps;
- a bitwise AND with a zero-extended immediate;
- an upper-half immediate load;
- a doubleword add that traps on overflow, and a doubleword add that never traps.

The doubleword forms are forbidden to unprivileged code running in narrow mode. The register file, instruction fetch and exception vectoring sit outside the block. The block only names the cause.

Top module: `ieu_imm_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wb_en`, `exc_valid`, `exc_code`, `wb_idx` and `wb_data` are all zero after that edge.
- R2: Results appear one clock edge after the operation is sampled with `in_valid` high. `wb_idx` equals the sampled `rt_idx` whenever `wb_en` is high.
- R3: Operation code 0 is a trapping word add. It adds `rs_val[31:0]` and the immediate sign-extended to 32 bits. Without overflow it writes the 32-bit sum, sign-extended from bit 31 to 64 bits.
- R4: For code 0, signed overflow occurs when both addends share a sign and the sum's sign differs. Overflow sets `exc_code` to 1 (overflow) and leaves `wb_en` low.
- R5: Code 1 is a non-trapping word add. It computes the same sum as code 0, never raises an exception, and always writes the sign-extended 32-bit result. `rs_val[63:32]` does not affect the result.
- R6: Code 2 writes `rs_val` ANDed with the immediate zero-extended to 64 bits.
- R7: Code 3 writes the immediate shifted left by 16, with bit 31 of that value sign-extended through bit 63.
- R8: Code 4 is a trapping doubleword add. It adds `rs_val` and the immediate sign-extended to 64 bits. On 64-bit signed overflow it reports `exc_code` 1 and does not write.
- R9: Code 5 is a non-trapping doubleword add. It writes the 64-bit wrapped sum and never raises an exception.
- R10: Codes 4 and 5 sampled with `mode32` high and `kernel` low report `exc_code` 2 (reserved instruction) and do not write. This takes priority over overflow. With `kernel` high, or with `mode32` low, they execute normally. Codes 0 to 3 are never reserved.
- R11: An operation whose `rt_idx` is 0 never raises `wb_en`. Any exception it causes is still reported.
- R12: `wb_en` and `exc_valid` are never high together. `exc_valid` is high exactly when `exc_code` is non-zero.
- R13: With `in_valid` low, or with operation codes 6 and 7, the next cycle has `wb_en` low and `exc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 to 5 defined) |
| rs_val | input | 64 | Source register value |
| imm | input | 16 | Instruction immediate |
| rt_idx | input | 5 | Destination register index |
| mode32 | input | 1 | Narrow (32-bit) operating mode |
| kernel | input | 1 | Privileged mode |
| wb_en | output | 1 | Write-back enable for `wb_idx` |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Write-back value |
| exc_valid | output | 1 | Exception raised by the operation |
| exc_code | output | 2 | 0 none, 1 overflow, 2 reserved instruction |

## Verification
The hardest cases are the overlaps between a mode fault and an arithmetic fault, and between any fault and a write to register 0. Random stimulus seldom hits an overflowing doubleword add in unprivileged narrow mode, or an overflowing word add aimed at register 0. The vector table therefore carries directed entries for these cases: one overflowing doubleword add with both mode flags set against it, and one overflowing word add with `rt_idx` zero. Each of these entries is checked for the cause that wins and for the absence of a write. Separate entries check the sign boundaries from both directions: positive plus positive, and negative plus negative.

// File: rtl/ieu_pkg.sv
// Shared encodings for the immediate-operand execute stage.
// Assumes: operation codes are produced by an upstream decoder.
package ieu_pkg;
    typedef enum logic [2:0] {
        OP_ADD_T  = 3'd0,
        OP_ADD_W  = 3'd1,
        OP_AND    = 3'd2,
        OP_UPPER  = 3'd3,
        OP_DADD_T = 3'd4,
        OP_DADD_W = 3'd5
    } ieu_op_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_OVF  = 2'd1,
        EXC_RSV  = 2'd2
    } ieu_exc_e;

    typedef enum logic [1:0] {
        SEL_SUM_NARROW = 2'd0,
        SEL_SUM_WIDE   = 2'd1,
        SEL_AND        = 2'd2,
        SEL_UPPER      = 2'd3
    } ieu_sel_e;
endpackage

// File: rtl/ieu_adder.sv
// Two's-complement adder with signed-overflow flag.
// Assumes: both operands are already extended to W bits.
module ieu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);
    // Sum, then flag overflow when the addend signs agree but the result sign does not
    always_comb begin
        sum = a + b;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/ieu_decode.sv
// Turns the operation code and mode flags into datapath controls.
// Assumes: op values 6 and 7 are undefined and do nothing.
module ieu_decode
    import ieu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       mode32,
    input  logic       kernel,
    output logic       known,
    output ieu_sel_e   sel,
    output logic       traps,
    output logic       reserved
);
    logic wide;

    // Classify the operation: result source, trapping behaviour, width
    always_comb begin
        known = 1'b1;
        sel   = SEL_SUM_NARROW;
        traps = 1'b0;
        wide  = 1'b0;
        case (op)
            OP_ADD_T:  traps = 1'b1;
            OP_ADD_W:  ;
            OP_AND:    sel = SEL_AND;
            OP_UPPER:  sel = SEL_UPPER;
            OP_DADD_T: begin sel = SEL_SUM_WIDE; traps = 1'b1; wide = 1'b1; end
            OP_DADD_W: begin sel = SEL_SUM_WIDE; wide = 1'b1; end
            default:   known = 1'b0;
        endcase
    end

    // Wide forms are forbidden to unprivileged code in narrow mode
    always_comb reserved = known && wide && mode32 && !kernel;
endmodule

// File: rtl/ieu_imm_exec.sv
// Immediate-operand execute stage: computes one result per accepted
// operation and registers either a write-back or an exception cause.
// Assumes: rs_val is already read; the consumer acts on the outputs
// for one cycle only.
module ieu_imm_exec
    import ieu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NARROW = 32,
    parameter int IMMW = 16,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] rs_val,
    input  logic [IMMW-1:0] imm,
    input  logic [RIDX-1:0] rt_idx,
    input  logic            mode32,
    input  logic            kernel,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            exc_valid,
    output logic [1:0]      exc_code
);
    localparam int SEXT_N = XLEN - IMMW;
    localparam int UPPER_SHIFT = 16;
    localparam int HI_N = XLEN - NARROW;

    logic            known, traps, reserved;
    ieu_sel_e        sel;
    logic [XLEN-1:0] imm_sx, imm_zx;
    logic [NARROW-1:0] sum_n;
    logic [XLEN-1:0] sum_w, upper_raw;
    logic            ovf_n, ovf_w;
    logic [XLEN-1:0] result;
    ieu_exc_e        exc_nx;
    logic            we_nx;

    ieu_decode u_dec (
        .op       (op),
        .mode32   (mode32),
        .kernel   (kernel),
        .known    (known),
        .sel      (sel),
        .traps    (traps),
        .reserved (reserved)
    );

    // Extend the immediate both ways
    always_comb begin
        imm_sx = {{SEXT_N{imm[IMMW-1]}}, imm};
        imm_zx = {{SEXT_N{1'b0}}, imm};
    end

    ieu_adder #(.W(NARROW)) u_add_n (
        .a   (rs_val[NARROW-1:0]),
        .b   (imm_sx[NARROW-1:0]),
        .sum (sum_n),
        .ovf (ovf_n)
    );

    ieu_adder #(.W(XLEN)) u_add_w (
        .a   (rs_val),
        .b   (imm_sx),
        .sum (sum_w),
        .ovf (ovf_w)
    );

    // Pick the result; narrow results are sign-extended to full width
    always_comb begin
        upper_raw = imm_zx << UPPER_SHIFT;
        case (sel)
            SEL_SUM_NARROW: result = {{HI_N{sum_n[NARROW-1]}}, sum_n};
            SEL_SUM_WIDE:   result = sum_w;
            SEL_AND:        result = rs_val & imm_zx;
            default:        result = {{HI_N{upper_raw[NARROW-1]}}, upper_raw[NARROW-1:0]};
        endcase
    end

    // Decide the cause: mode fault first, then overflow of the trapping forms
    always_comb begin
        exc_nx = EXC_NONE;
        if (in_valid && known) begin
            if (reserved)
                exc_nx = EXC_RSV;
            else if (traps && (sel == SEL_SUM_WIDE ? ovf_w : ovf_n))
                exc_nx = EXC_OVF;
        end
        we_nx = in_valid && known && (exc_nx == EXC_NONE) && (rt_idx != '0);
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            exc_valid <= 1'b0;
            exc_code  <= EXC_NONE;
        end else begin
            wb_en     <= we_nx;
            wb_idx    <= rt_idx;
            wb_data   <= result;
            exc_valid <= (exc_nx != EXC_NONE);
            exc_code  <= exc_nx;
        end
    end
endmodule

// File: rtl/ieu_imm_exec_chk.sv
// Property checker for the immediate-operand execute stage.
module ieu_imm_exec_chk #(
    parameter int XLEN = 64,
    parameter int RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic [RIDX-1:0] rt_idx,
    input logic            mode32,
    input logic            kernel,
    input logic            wb_en,
    input logic [RIDX-1:0] wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic            exc_valid,
    input logic [1:0]      exc_code
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!wb_en && !exc_valid && exc_code == 2'd0));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && exc_valid));

    a_r12_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid == (exc_code != 2'd0));

    a_r11_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || op[2:1] == 2'b11) |=> (!wb_en && !exc_valid));

    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b10 && mode32 && !kernel) |=> (exc_code == 2'd2 && !wb_en));

    a_r5_never_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1 && rt_idx != '0) |=> (wb_en && !exc_valid));

    a_r7_low_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3 && rt_idx != '0) |=> (wb_en && wb_data[15:0] == 16'h0));
endmodule

bind ieu_imm_exec ieu_imm_exec_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .rt_idx    (rt_idx),
    .mode32    (mode32),
    .kernel    (kernel),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data),
    .exc_valid (exc_valid),
    .exc_code  (exc_code)
);

// File: tb/ieu_imm_exec_test.sv
module ieu_imm_exec_test;
    typedef struct packed {
        logic [2:0]  op;
        logic [63:0] rs;
        logic [15:0] imm;
        logic [4:0]  rt;
        logic        m32;
        logic        kern;
        logic        we;
        logic [63:0] data;
        logic [1:0]  exc;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R3 plain word add
        '{3'd0, 64'd5, 16'hFFFF, 5'd3, 1'b0, 1'b0, 1'b1, 64'd4, 2'd0},
        // R4 positive overflow
        '{3'd0, 64'h0000_0000_7FFF_FFFF, 16'h0001, 5'd4, 1'b0, 1'b0, 1'b0, 64'd0, 2'd1},
        // R4 negative overflow
        '{3'd0, 64'h0000_0000_8000_0000, 16'h8000, 5'd4, 1'b0, 1'b0, 1'b0, 64'd0, 2'd1},
        // R3 largest positive without overflow
        '{3'd0, 64'h0000_0000_7FFF_FFF0, 16'h000F, 5'd5, 1'b0, 1'b0, 1'b1, 64'h0000_0000_7FFF_FFFF, 2'd0},
        // R3 negative result sign-extended
        '{3'd0, 64'hFFFF_FFFF_FFFF_FFFE, 16'h0001, 5'd6, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0},
        // R5 wraps without trap
        '{3'd1, 64'h0000_0000_7FFF_FFFF, 16'h0001, 5'd7, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_8000_0000, 2'd0},
        // R5 upper half of rs ignored
        '{3'd1, 64'h1234_5678_0000_0010, 16'hFFF0, 5'd8, 1'b0, 1'b0, 1'b1, 64'd0, 2'd0},
        // R6 zero-extended mask
        '{3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8001, 5'd9, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_8001, 2'd0},
        // R7 upper load with sign bit
        '{3'd3, 64'hDEAD_BEEF_0000_0000, 16'h8000, 5'd10, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_8000_0000, 2'd0},
        // R7 upper load positive
        '{3'd3, 64'd0, 16'h1234, 5'd11, 1'b0, 1'b0, 1'b1, 64'h0000_0000_1234_0000, 2'd0},
        // R8 doubleword overflow
        '{3'd4, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 5'd12, 1'b0, 1'b0, 1'b0, 64'd0, 2'd1},
        // R8 doubleword borrow across word
        '{3'd4, 64'h0000_0001_0000_0000, 16'hFFFF, 5'd13, 1'b0, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 2'd0},
        // R9 doubleword wrap
        '{3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 5'd14, 1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 2'd0},
        // R10 reserved, trapping form
        '{3'd4, 64'd1, 16'h0001, 5'd15, 1'b1, 1'b0, 1'b0, 64'd0, 2'd2},
        // R10 reserved, non-trapping form
        '{3'd5, 64'd1, 16'h0001, 5'd16, 1'b1, 1'b0, 1'b0, 64'd0, 2'd2},
        // R10 privileged narrow mode allowed
        '{3'd5, 64'd5, 16'h0003, 5'd17, 1'b1, 1'b1, 1'b1, 64'd8, 2'd0},
        // R11 zero destination, no fault
        '{3'd0, 64'd1, 16'h0001, 5'd0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd0},
        // R11 zero destination, fault still reported
        '{3'd0, 64'h0000_0000_7FFF_FFFF, 16'h0001, 5'd0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd1},
        // R13 undefined code
        '{3'd6, 64'd1, 16'h0001, 5'd18, 1'b0, 1'b0, 1'b0, 64'd0, 2'd0},
        // R10 word add never reserved
        '{3'd0, 64'd2, 16'h0002, 5'd19, 1'b1, 1'b0, 1'b1, 64'd4, 2'd0},
        // R10 reserved beats overflow
        '{3'd4, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 5'd20, 1'b1, 1'b0, 1'b0, 64'd0, 2'd2},
        // R8 doubleword negative overflow
        '{3'd4, 64'h8000_0000_0000_0000, 16'hFFFF, 5'd21, 1'b0, 1'b0, 1'b0, 64'd0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] rs_val = '0;
    logic [15:0] imm = '0;
    logic [4:0]  rt_idx = '0;
    logic        mode32 = 1'b0;
    logic        kernel = 1'b0;
    logic        wb_en, exc_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic [1:0]  exc_code;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ieu_imm_exec uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rs_val(rs_val), .imm(imm), .rt_idx(rt_idx), .mode32(mode32),
        .kernel(kernel), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .exc_valid(exc_valid), .exc_code(exc_code)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.op[2:1] == 2'b11) return "R13";
        if (v.exc == 2'd2 || v.m32) return "R10";
        if (v.rt == 5'd0) return "R11";
        case (v.op)
            3'd0: return (v.exc == 2'd1) ? "R4" : "R3";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Watchdog: a hung run is counted as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "wb_en", {63'd0, wb_en}, 64'd0);
        chk("R1", "exc_valid", {63'd0, exc_valid}, 64'd0);
        chk("R1", "wb_data", wb_data, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            op = VECS[i].op; rs_val = VECS[i].rs; imm = VECS[i].imm;
            rt_idx = VECS[i].rt; mode32 = VECS[i].m32; kernel = VECS[i].kern;
            @(negedge clk);
            chk(tag_of(VECS[i]), "wb_en", {63'd0, wb_en}, {63'd0, VECS[i].we});
            chk(tag_of(VECS[i]), "exc_code", {62'd0, exc_code}, {62'd0, VECS[i].exc});
            chk("R12", "exc_valid", {63'd0, exc_valid}, {63'd0, VECS[i].exc != 2'd0});
            if (VECS[i].we) begin
                chk(tag_of(VECS[i]), "wb_data", wb_data, VECS[i].data);
                chk("R2", "wb_idx", {59'd0, wb_idx}, {59'd0, VECS[i].rt});
            end
        end

        // R13 idle cycle after a valid write
        op = 3'd1; rs_val = 64'd9; imm = 16'd1; rt_idx = 5'd2; mode32 = 1'b0; kernel = 1'b0;
        @(negedge clk);
        chk("R5", "wb_en", {63'd0, wb_en}, 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R13", "wb_en idle", {63'd0, wb_en}, 64'd0);
        chk("R13", "exc_valid idle", {63'd0, exc_valid}, 64'd0);

        // R2 latency: result not visible before the edge
        in_valid = 1'b1; op = 3'd2; rs_val = 64'hFF; imm = 16'h0F; rt_idx = 5'd1;
        #1;
        chk("R2", "no early write", {63'd0, wb_en}, 64'd0);
        @(negedge clk);
        chk("R2", "result after one edge", wb_data, 64'h0F);

        // R1 reset during a faulting operation
        op = 3'd0; rs_val = 64'h7FFF_FFFF; imm = 16'd1; rt_idx = 5'd3;
        @(negedge clk);
        chk("R4", "fault before reset", {62'd0, exc_code}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "exc_valid in reset", {63'd0, exc_valid}, 64'd0);
        chk("R1", "exc_code in reset", {62'd0, exc_code}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule